// File: doc/BRIEF.md
# Link Turnaround and Receive Watchdog Controller

This block sits between the packet engine of a serial display host link and its physical layer, in the low-power escape-clock domain. When the packet engine reports that a packet expecting an answer from the panel has gone out, such as a read request or a command that enables the tear signal, the block waits a programmable number of cycles with the lanes held in stop state. It then raises a turnaround request so that the physical layer hands the bus to the panel.

Two watchdogs guard the exchange. The first limits how long the turnaround request may stay pending before the physical layer reports that the direction has reversed. The second limits how long, once the link is reversed and the physical layer is in low-power receive, the receive-valid indication may stay low. Both limits are counted in escape-clock cycles, and a limit of zero switches the watchdog off. Three sticky event flags record a turnaround timeout, a receive timeout and a completed turnaround. Each flag is cleared by writing one to it, and one maskable interrupt line merges them. Software may also request a turnaround directly, or force the lanes back to stop state.

Top module: `dsi_turn_ctrl`

## Requirements
- R1: A `pkt_done` pulse with `pkt_reply`=1, sampled while idle, asserts `turn_req` after `hold_cnt` clock edges, counted from the edge that samples it. With `hold_cnt`=0 the request appears right after that edge. A `pkt_done` with `pkt_reply`=0 leaves `turn_req` low.
- R2: A `force_turn` pulse, sampled while idle or while the hold interval is running, asserts `turn_req` after that same edge and skips the rest of the hold interval.
- R3: With `ta_limit`=L (nonzero), if `phy_dir_rev` stays 0 for L edges after `turn_req` rises, `turn_req` drops after the L-th edge and `irq_src[20]` is set at that edge.
- R4: If `phy_dir_rev` is sampled 1 while `turn_req` is high, `turn_req` drops after that edge and `irq_src[25]` is set. `dir_status` is the value of `phy_dir_rev` registered on each edge (1 = reverse, 0 = forward).
- R5: While reversed, `irq_src[21]` is set on the L-th consecutive edge (L = `rx_limit`, nonzero) that samples `phy_rx_lp`=1 and `phy_rx_valid`=0. Any edge that breaks this condition restarts the count.
- R6: A limit of zero disables the matching watchdog: with `ta_limit`=0 the request stays high indefinitely, and with `rx_limit`=0 bit 21 never sets.
- R7: While reversed, an edge that samples `phy_dir_rev`=0 returns the block to idle, and the next qualifying packet starts a new request.
- R8: A `force_stop` pulse, in any state, lowers `turn_req` after the sampling edge and gives a one-cycle `stop_req` pulse after the same edge. `force_stop` has priority over every other input.
- R9: The `irq_src` bits are sticky. Writing 1 on `irq_clr` clears the matching bit at the next edge. If a bit is set and cleared in the same cycle, the set wins. All `irq_src` bits other than 20, 21 and 25 read 0.
- R10: `irq` is the OR of the `irq_src` bits whose `irq_mask` bit is 0, registered on the same edge as `irq_src`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Escape clock |
| rst | input | 1 | Synchronous reset, active high |
| pkt_done | input | 1 | One-cycle pulse: a packet finished transmission |
| pkt_reply | input | 1 | Qualifies pkt_done: the packet expects a reply |
| force_turn | input | 1 | Software turnaround request pulse |
| force_stop | input | 1 | Software stop-state request pulse |
| hold_cnt | input | 10 | Stop-state hold cycles before the request |
| ta_limit | input | 8 | Turnaround timeout, 0 disables |
| rx_limit | input | 16 | Receive-valid timeout, 0 disables |
| phy_dir_rev | input | 1 | PHY direction, 1 = reverse |
| phy_rx_lp | input | 1 | PHY is in low-power receive |
| phy_rx_valid | input | 1 | PHY receive data valid |
| irq_clr | input | 32 | Write-one-to-clear strobes for irq_src |
| irq_mask | input | 32 | Interrupt mask, 1 = masked |
| turn_req | output | 1 | Turnaround request to the PHY |
| stop_req | output | 1 | One-cycle stop-state request to the PHY |
| dir_status | output | 1 | Registered link direction |
| irq_src | output | 32 | Sticky event flags (bits 20, 21, 25) |
| irq | output | 1 | Merged unmasked interrupt |

## Verification
The receive timeout is the hardest case to reach. It needs a completed turnaround first, and then an unbroken run of low-power-receive cycles with no valid data. The bench drives a turnaround to completion by raising the reverse direction while the request is pending. It then holds the receive inputs in the timing-out combination, breaks the run once with a single valid cycle to prove that the count restarts, and finally lets the full limit elapse. The turnaround-timeout case is checked on both sides of its edge, as are the masked and unmasked forms of the interrupt.

// File: rtl/dsi_turn_pkg.sv
package dsi_turn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_REQ  = 2'd2,
    ST_REV  = 2'd3
  } turn_st_t;

  localparam int IRQ_W      = 32;
  localparam int BIT_TA_TO  = 20;
  localparam int BIT_RX_TO  = 21;
  localparam int BIT_TURNED = 25;
  localparam int NUM_EVT    = 3;
  localparam int EV_TA      = 0;
  localparam int EV_RX      = 1;
  localparam int EV_DONE    = 2;
endpackage

// File: rtl/dsi_turn_wdog.sv
module dsi_turn_wdog #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;
  logic         fired;
  logic [W:0]   nxt;

  assign nxt = {1'b0, cnt} + 1'b1;
  assign hit = run && !fired && (limit != '0) && (nxt == {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (!fired) begin
      if (hit) begin
        fired <= 1'b1;
        cnt   <= '0;
      end else begin
        cnt <= nxt[W-1:0];
      end
    end
  end
endmodule

// File: rtl/dsi_turn_seq.sv
module dsi_turn_seq
  import dsi_turn_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     pkt_done,
  input  logic     pkt_reply,
  input  logic     force_turn,
  input  logic     force_stop,
  input  logic     phy_dir_rev,
  input  logic     hold_zero,
  input  logic     hold_hit,
  input  logic     ta_hit,
  output turn_st_t state,
  output logic     ev_done,
  output logic     ev_ta
);
  turn_st_t nxt;

  always_comb begin
    nxt     = state;
    ev_done = 1'b0;
    ev_ta   = 1'b0;
    if (force_stop) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (force_turn) nxt = ST_REQ;
          else if (pkt_done && pkt_reply) nxt = hold_zero ? ST_REQ : ST_HOLD;
        end
        ST_HOLD: begin
          if (force_turn || hold_hit) nxt = ST_REQ;
        end
        ST_REQ: begin
          if (phy_dir_rev) begin
            nxt     = ST_REV;
            ev_done = 1'b1;
          end else if (ta_hit) begin
            nxt   = ST_IDLE;
            ev_ta = 1'b1;
          end
        end
        ST_REV: begin
          if (!phy_dir_rev) nxt = ST_IDLE;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/dsi_turn_evt.sv
module dsi_turn_evt
  import dsi_turn_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM_EVT-1:0] set,
  input  logic [IRQ_W-1:0] clr,
  input  logic [IRQ_W-1:0] mask,
  output logic [IRQ_W-1:0] src,
  output logic             irq
);
  localparam int POS [NUM_EVT] = '{BIT_TA_TO, BIT_RX_TO, BIT_TURNED};

  logic [NUM_EVT-1:0] flag_q, flag_d, en;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assign flag_d[i] = set[i] | (flag_q[i] & ~clr[POS[i]]);
    assign en[i]     = ~mask[POS[i]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq    <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq    <= |(flag_d & en);
    end
  end

  always_comb begin
    src = '0;
    for (int i = 0; i < NUM_EVT; i++) src[POS[i]] = flag_q[i];
  end
endmodule

// File: rtl/dsi_turn_ctrl.sv
module dsi_turn_ctrl
  import dsi_turn_pkg::*;
#(
  parameter int HOLD_W = 10,
  parameter int TA_W   = 8,
  parameter int RX_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_done,
  input  logic              pkt_reply,
  input  logic              force_turn,
  input  logic              force_stop,
  input  logic [HOLD_W-1:0] hold_cnt,
  input  logic [TA_W-1:0]   ta_limit,
  input  logic [RX_W-1:0]   rx_limit,
  input  logic              phy_dir_rev,
  input  logic              phy_rx_lp,
  input  logic              phy_rx_valid,
  input  logic [IRQ_W-1:0]  irq_clr,
  input  logic [IRQ_W-1:0]  irq_mask,
  output logic              turn_req,
  output logic              stop_req,
  output logic              dir_status,
  output logic [IRQ_W-1:0]  irq_src,
  output logic              irq
);
  turn_st_t           state;
  logic               hold_run, ta_run, rx_run;
  logic               hold_hit, ta_hit, rx_hit;
  logic               ev_done, ev_ta;
  logic [NUM_EVT-1:0] ev_set;

  assign hold_run = (state == ST_HOLD) && !force_stop && !force_turn;
  assign ta_run   = (state == ST_REQ) && !phy_dir_rev && !force_stop;
  assign rx_run   = (state == ST_REV) && phy_dir_rev && phy_rx_lp &&
                    !phy_rx_valid && !force_stop;

  dsi_turn_wdog #(.W(HOLD_W)) u_hold (
    .clk(clk), .rst(rst), .run(hold_run), .limit(hold_cnt), .hit(hold_hit));
  dsi_turn_wdog #(.W(TA_W)) u_ta (
    .clk(clk), .rst(rst), .run(ta_run), .limit(ta_limit), .hit(ta_hit));
  dsi_turn_wdog #(.W(RX_W)) u_rx (
    .clk(clk), .rst(rst), .run(rx_run), .limit(rx_limit), .hit(rx_hit));

  dsi_turn_seq u_seq (
    .clk(clk), .rst(rst), .pkt_done(pkt_done), .pkt_reply(pkt_reply),
    .force_turn(force_turn), .force_stop(force_stop),
    .phy_dir_rev(phy_dir_rev), .hold_zero(hold_cnt == '0),
    .hold_hit(hold_hit), .ta_hit(ta_hit), .state(state),
    .ev_done(ev_done), .ev_ta(ev_ta));

  always_comb begin
    ev_set          = '0;
    ev_set[EV_TA]   = ev_ta;
    ev_set[EV_RX]   = rx_hit;
    ev_set[EV_DONE] = ev_done;
  end

  dsi_turn_evt u_evt (
    .clk(clk), .rst(rst), .set(ev_set), .clr(irq_clr), .mask(irq_mask),
    .src(irq_src), .irq(irq));

  assign turn_req = (state == ST_REQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_req   <= 1'b0;
      dir_status <= 1'b0;
    end else begin
      stop_req   <= force_stop;
      dir_status <= phy_dir_rev;
    end
  end
endmodule

// File: rtl/dsi_turn_chk.sv
module dsi_turn_chk (
  input logic        clk,
  input logic        rst,
  input logic        turn_req,
  input logic        stop_req,
  input logic        dir_status,
  input logic [31:0] irq_src,
  input logic [31:0] irq_clr,
  input logic [31:0] irq_mask,
  input logic        irq
);
  // R8
  stop_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
    stop_req |-> !turn_req);
  // R9
  ta_flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_src[20] && !irq_clr[20]) |=> irq_src[20]);
  // R9
  done_flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_src[25] && !irq_clr[25]) |=> irq_src[25]);
  // R10
  irq_merge_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(rst) |-> (irq == |(irq_src & ~$past(irq_mask))));
  // R4
  done_sees_reverse_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_src[25]) |-> dir_status);
  // R3
  ta_timeout_drops_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_src[20]) |-> $fell(turn_req));
endmodule

bind dsi_turn_ctrl dsi_turn_chk u_chk (
  .clk(clk), .rst(rst), .turn_req(turn_req), .stop_req(stop_req),
  .dir_status(dir_status), .irq_src(irq_src), .irq_clr(irq_clr),
  .irq_mask(irq_mask), .irq(irq));

// File: tb/dsi_turn_ctrl_tb.sv
module dsi_turn_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pkt_done = 0, pkt_reply = 0, force_turn = 0, force_stop = 0;
  logic [9:0]  hold_cnt = 0;
  logic [7:0]  ta_limit = 0;
  logic [15:0] rx_limit = 0;
  logic        phy_dir_rev = 0, phy_rx_lp = 0, phy_rx_valid = 0;
  logic [31:0] irq_clr = 0, irq_mask = 0;
  logic        turn_req, stop_req, dir_status, irq;
  logic [31:0] irq_src;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dsi_turn_ctrl u_dut (
    .clk(clk), .rst(rst), .pkt_done(pkt_done), .pkt_reply(pkt_reply),
    .force_turn(force_turn), .force_stop(force_stop), .hold_cnt(hold_cnt),
    .ta_limit(ta_limit), .rx_limit(rx_limit), .phy_dir_rev(phy_dir_rev),
    .phy_rx_lp(phy_rx_lp), .phy_rx_valid(phy_rx_valid), .irq_clr(irq_clr),
    .irq_mask(irq_mask), .turn_req(turn_req), .stop_req(stop_req),
    .dir_status(dir_status), .irq_src(irq_src), .irq(irq));

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(string tag, logic [31:0] act, logic [31:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic send_pkt(bit reply);
    pkt_done = 1; pkt_reply = reply;
    tick(1);
    pkt_done = 0; pkt_reply = 0;
  endtask

  task automatic clear_all();
    irq_clr = 32'hffff_ffff;
    tick(1);
    irq_clr = 0;
  endtask

  task automatic stop_now();
    force_stop = 1;
    tick(1);
    force_stop = 0;
  endtask

  task automatic t_reset();
    chk_eq("R1 reset turn_req", turn_req, 0);
    chk_eq("R8 reset stop_req", stop_req, 0);
    chk_eq("R9 reset irq_src", irq_src, 0);
    chk_eq("R10 reset irq", irq, 0);
    chk_eq("R4 reset dir_status", dir_status, 0);
  endtask

  task automatic t_hold();
    ta_limit = 0; hold_cnt = 3;
    send_pkt(0);
    tick(5);
    chk_eq("R1 unqualified packet ignored", turn_req, 0);
    send_pkt(1);
    tick(2);
    chk_eq("R1 still holding", turn_req, 0);
    tick(1);
    chk_eq("R1 request after hold", turn_req, 1);
    stop_now();
    hold_cnt = 0;
    send_pkt(1);
    chk_eq("R1 zero hold immediate", turn_req, 1);
    stop_now();
  endtask

  task automatic t_force();
    hold_cnt = 10;
    force_turn = 1; tick(1); force_turn = 0;
    chk_eq("R2 force turn skips hold", turn_req, 1);
    stop_now();
    send_pkt(1);
    tick(2);
    chk_eq("R2 hold running", turn_req, 0);
    force_turn = 1; tick(1); force_turn = 0;
    chk_eq("R2 force during hold", turn_req, 1);
    force_stop = 1; tick(1); force_stop = 0;
    chk_eq("R8 stop_req pulse", stop_req, 1);
    chk_eq("R8 request dropped", turn_req, 0);
    tick(1);
    chk_eq("R8 stop_req one cycle", stop_req, 0);
  endtask

  task automatic t_ta_timeout();
    hold_cnt = 0; ta_limit = 4;
    send_pkt(1);
    tick(3);
    chk_eq("R3 before timeout req", turn_req, 1);
    chk_eq("R3 before timeout flag", irq_src[20], 0);
    tick(1);
    chk_eq("R3 timeout drops req", turn_req, 0);
    chk_eq("R3 timeout flag", irq_src[20], 1);
    chk_eq("R10 irq unmasked", irq, 1);
    tick(3);
    chk_eq("R9 flag sticky", irq_src[20], 1);
    irq_mask = 32'h0010_0000; tick(1);
    chk_eq("R10 irq masked", irq, 0);
    irq_mask = 0; tick(1);
    chk_eq("R10 irq unmasked again", irq, 1);
    clear_all();
    chk_eq("R9 w1c clears", irq_src, 0);
    chk_eq("R10 irq after clear", irq, 0);
  endtask

  task automatic t_zero_ta();
    ta_limit = 0;
    send_pkt(1);
    tick(300);
    chk_eq("R6 zero ta limit keeps req", turn_req, 1);
    chk_eq("R6 no ta flag", irq_src[20], 0);
    stop_now();
  endtask

  task automatic t_turn_rx();
    ta_limit = 20; rx_limit = 4;
    send_pkt(1);
    phy_dir_rev = 1;
    tick(1);
    chk_eq("R4 req drops on reverse", turn_req, 0);
    chk_eq("R4 done flag", irq_src[25], 1);
    chk_eq("R4 dir_status reverse", dir_status, 1);
    irq_clr[25] = 1; tick(1); irq_clr = 0;
    chk_eq("R9 clear done flag", irq_src[25], 0);
    phy_rx_lp = 1; phy_rx_valid = 0;
    tick(2);
    phy_rx_valid = 1; tick(1); phy_rx_valid = 0;
    tick(3);
    chk_eq("R5 count restarted", irq_src[21], 0);
    tick(1);
    chk_eq("R5 rx timeout flag", irq_src[21], 1);
    chk_eq("R9 no other bits", irq_src & ~32'h0230_0000, 0);
    phy_rx_lp = 0;
    clear_all();
    phy_dir_rev = 0;
    tick(1);
    chk_eq("R7 back forward", dir_status, 0);
    hold_cnt = 0;
    send_pkt(1);
    chk_eq("R7 rearmed request", turn_req, 1);
    phy_dir_rev = 1; tick(1);
    rx_limit = 0; phy_rx_lp = 1;
    tick(50);
    chk_eq("R6 zero rx limit", irq_src[21], 0);
    phy_rx_lp = 0; phy_dir_rev = 0;
    tick(1);
    clear_all();
  endtask

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    t_reset();
    t_hold();
    t_force();
    t_ta_timeout();
    t_zero_ta();
    t_turn_rx();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule